// File: doc/BRIEF.md
# Double-Buffered Processor-Device Data Controller

This block moves 36-bit words between a processor I/O bus and one of up to eight fast peripheral ports. Each word passes through two registers. A buffer register faces the processor. An accumulator register faces the device. A 16-bit control/status word sets the transfer direction, the selected port and the interrupt priority. It also holds three handshake flags:

- request: the buffer needs processor service
- accumulator-full: the device side has finished with a word
- move-pending: a transfer between the two registers is due

The processor issues one operation per cycle: a control write, a status read, a data read or a data write. A device strobes a single-cycle read or write request carrying its port number, and the block answers a granted request with a one-cycle acknowledge. Each data hand-off arms a delay timer. When the timer runs out, the block copies the word between the buffer and the accumulator in the programmed direction, and raises the request flag again. The block also reports continuously whether the port presented on the device side is still connected.

Top module: `dbl_buf_dctl`

## Requirements
- R1: A synchronous active-high reset clears the status word, buffer, accumulator, timer and every output; a status read right after reset returns zero.
- R2: A control write (`cpu_op` 0) loads status bits 12:0 from `cpu_wdata[12:0]` and clears the character count (bits 15:13). The status layout is:
  - bits 2:0 priority
  - bits 5:3 selected port
  - bits 7:6 packing
  - bit 8 direction (1 = processor to device)
  - bit 9 request
  - bit 10 accumulator-full
  - bit 11 move-pending
  - bit 12 missed
  - bits 15:13 count

  A status read (`cpu_op` 1) returns the status word zero-extended on `cpu_rdata` on the following cycle.
- R3: While request is set, a data read (`cpu_op` 2) returns the buffer on `cpu_rdata` and a data write (`cpu_op` 3) loads the buffer from `cpu_wdata`. Either operation clears request and the count, and sets move-pending.
- R4: While request is clear, a data read returns zero and neither data operation changes the status, the buffer or the accumulator.
- R5: The move check runs exactly `CPU_DELAY` cycles (default 10) after a granted processor data operation, and `DEV_DELAY` cycles (default 20) after a device grant.
- R6: The move check copies only when move-pending and accumulator-full are set and request is clear. With direction 1 it copies buffer to accumulator; with direction 0 it copies accumulator to buffer. It then clears move-pending and accumulator-full and sets request.
- R7: A device read request is granted when `dev_port` equals the selected port, direction is 1 and accumulator-full is clear. On a grant, `dev_ack` pulses for one cycle with the accumulator on `dev_rdata`. Accumulator-full and move-pending are then set and the count is loaded from `dev_cnt`.
- R8: A device write request is granted when `dev_port` matches, direction is 0 and accumulator-full is clear. On a grant, `dev_wdata` is loaded into the accumulator, `dev_ack` pulses, and the flags and count are set as in R7.
- R9: A denied device request (wrong port, wrong direction or accumulator-full set) gives no acknowledge and changes no state.
- R10: `dev_link_ok` is registered each cycle from the pre-edge status. It is 1 only when `dev_port` equals the selected port and it is not the case that direction is 1 while accumulator-full is set.
- R11: `irq_req` is high exactly while request is set, and `irq_pri` shows status bits 2:0.
- R12: A processor control write or data operation in a cycle takes precedence. A device request in the same cycle is denied, and a move check falling due in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor operation present this cycle |
| cpu_op | input | 2 | 0 control write, 1 status read, 2 data read, 3 data write |
| cpu_wdata | input | 36 | Processor write word |
| cpu_rdata | output | 36 | Registered read result |
| irq_req | output | 1 | Interrupt request |
| irq_pri | output | 3 | Programmed priority level |
| dev_rd_req | input | 1 | Device read strobe |
| dev_wr_req | input | 1 | Device write strobe |
| dev_port | input | 3 | Port number of the requesting or queried device |
| dev_cnt | input | 3 | Character count supplied with a device request |
| dev_wdata | input | 36 | Device write word |
| dev_ack | output | 1 | One-cycle grant acknowledge |
| dev_rdata | output | 36 | Word handed to the device on a read grant |
| dev_link_ok | output | 1 | Connection status for `dev_port` |

## Verification
The hardest situation to reach is a move check that falls due in the same cycle as a processor operation, because the timer is invisible at the ports. The stimulus arms the timer with a device grant, counts idle cycles exactly, and issues a data write with request clear on the very edge the check is due. It then shows through status reads that no copy ever happens. A long random phase then mixes all operations, restricted to two ports, so that grants, denials and delayed moves overlap often. A behavioural model checks every output on every cycle of that phase.

// File: rtl/dctl_pkg.sv
package dctl_pkg;
  typedef enum logic [1:0] {
    OP_CTL_WR  = 2'd0,
    OP_STAT_RD = 2'd1,
    OP_DATA_RD = 2'd2,
    OP_DATA_WR = 2'd3
  } cpu_op_e;

  // Field order is the software-visible status layout, MSB first.
  typedef struct packed {
    logic [2:0] cnt;
    logic       miss;
    logic       mv;
    logic       ac;
    logic       rq;
    logic       dir;
    logic [1:0] pack;
    logic [2:0] port;
    logic [2:0] pri;
  } ctl_stat_t;

  localparam int STAT_W = $bits(ctl_stat_t);
  localparam int LOAD_W = 13;
endpackage

// File: rtl/dctl_move_timer.sv
module dctl_move_timer #(
  parameter int CPU_DELAY = 10,
  parameter int DEV_DELAY = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_cpu,
  input  logic trig_dev,
  output logic fire
);
  localparam int DLY_MAX = (CPU_DELAY > DEV_DELAY) ? CPU_DELAY : DEV_DELAY;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);

  logic [DLY_W-1:0] cnt_q;

  assign fire = (cnt_q == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (trig_dev)      cnt_q <= DLY_W'(DEV_DELAY);
    else if (trig_cpu)      cnt_q <= DLY_W'(CPU_DELAY);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // R5
  tmr_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DLY_W'(DLY_MAX));
endmodule

// File: rtl/dctl_port_gate.sv
module dctl_port_gate #(
  parameter int WORD_W = 36,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [PORT_W-1:0] req_port,
  input  logic [PORT_W-1:0] sel_port,
  input  logic              dir,
  input  logic              ac_i,
  input  logic              blocked,
  input  logic [WORD_W-1:0] acc_i,
  output logic              grant_rd,
  output logic              grant_wr,
  output logic              ack,
  output logic [WORD_W-1:0] rdata,
  output logic              link_ok
);
  logic match;

  assign match    = (req_port == sel_port);
  assign grant_rd = rd_req && !blocked && match &&  dir && !ac_i;
  assign grant_wr = wr_req && !blocked && match && !dir && !ac_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack     <= 1'b0;
      rdata   <= '0;
      link_ok <= 1'b0;
    end else begin
      ack     <= grant_rd || grant_wr;
      link_ok <= match && !(dir && ac_i);
      if (grant_rd) rdata <= acc_i;
    end
  end

  // R9
  ack_needs_free_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> !$past(ac_i));
endmodule

// File: rtl/dbl_buf_dctl.sv
module dbl_buf_dctl
  import dctl_pkg::*;
#(
  parameter int WORD_W    = 36,
  parameter int CPU_DELAY = 10,
  parameter int DEV_DELAY = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              irq_req,
  output logic [2:0]        irq_pri,
  input  logic              dev_rd_req,
  input  logic              dev_wr_req,
  input  logic [2:0]        dev_port,
  input  logic [2:0]        dev_cnt,
  input  logic [WORD_W-1:0] dev_wdata,
  output logic              dev_ack,
  output logic [WORD_W-1:0] dev_rdata,
  output logic              dev_link_ok
);
  localparam int PAD_W = WORD_W - STAT_W;

  ctl_stat_t         st;
  logic [WORD_W-1:0] buf_q, acc_q;
  logic              irq_q;
  cpu_op_e           op_e;
  logic              cpu_wr_op, data_op, trig_cpu;
  logic              grant_rd, grant_wr, any_grant, fire, move_ok;

  assign op_e      = cpu_op_e'(cpu_op);
  assign cpu_wr_op = cpu_valid && (op_e != OP_STAT_RD);
  assign data_op   = cpu_valid && (op_e == OP_DATA_RD || op_e == OP_DATA_WR);
  assign trig_cpu  = data_op && st.rq;
  assign any_grant = grant_rd || grant_wr;
  assign move_ok   = fire && st.mv && st.ac && !st.rq && !cpu_wr_op && !any_grant;
  assign irq_req   = irq_q;
  assign irq_pri   = st.pri;

  dctl_move_timer #(.CPU_DELAY(CPU_DELAY), .DEV_DELAY(DEV_DELAY)) u_timer (
    .clk(clk), .rst(rst), .trig_cpu(trig_cpu), .trig_dev(any_grant), .fire(fire));

  dctl_port_gate #(.WORD_W(WORD_W), .PORT_W(3)) u_gate (
    .clk(clk), .rst(rst), .rd_req(dev_rd_req), .wr_req(dev_wr_req),
    .req_port(dev_port), .sel_port(st.port), .dir(st.dir), .ac_i(st.ac),
    .blocked(cpu_wr_op), .acc_i(acc_q), .grant_rd(grant_rd), .grant_wr(grant_wr),
    .ack(dev_ack), .rdata(dev_rdata), .link_ok(dev_link_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= '0;
      buf_q     <= '0;
      acc_q     <= '0;
      irq_q     <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (cpu_valid && op_e == OP_STAT_RD)
        cpu_rdata <= {{PAD_W{1'b0}}, st};
      if (cpu_wr_op) begin
        unique case (op_e)
          OP_CTL_WR: begin
            st    <= ctl_stat_t'({3'b000, cpu_wdata[LOAD_W-1:0]});
            irq_q <= cpu_wdata[9];
          end
          OP_DATA_RD: begin
            irq_q     <= 1'b0;
            cpu_rdata <= st.rq ? buf_q : '0;
            if (st.rq) begin
              st.rq  <= 1'b0;
              st.cnt <= '0;
              st.mv  <= 1'b1;
            end
          end
          OP_DATA_WR: begin
            irq_q <= 1'b0;
            if (st.rq) begin
              buf_q  <= cpu_wdata;
              st.rq  <= 1'b0;
              st.cnt <= '0;
              st.mv  <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (any_grant) begin
        if (grant_wr) acc_q <= dev_wdata;
        st.ac  <= 1'b1;
        st.mv  <= 1'b1;
        st.cnt <= dev_cnt;
      end else if (move_ok) begin
        if (st.dir) acc_q <= buf_q;
        else        buf_q <= acc_q;
        st.mv <= 1'b0;
        st.ac <= 1'b0;
        st.rq <= 1'b1;
        irq_q <= 1'b1;
      end
    end
  end

  // R11
  irq_tracks_rq_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == st.rq);

  // R6
  move_needs_flags_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(st.rq) && !$past(cpu_valid && op_e == OP_CTL_WR)) |-> $past(st.mv && st.ac));

  // R4
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && op_e == OP_DATA_WR && !st.rq) |=> ($stable(buf_q) && $stable(st)));

  // R7
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> !dev_ack);
endmodule

// File: tb/test_dbl_buf_dctl.sv
`timescale 1ns/1ps
module test_dbl_buf_dctl;
  logic        clk = 1'b0, rst = 1'b1;
  logic        cv = 1'b0;
  logic [1:0]  cop = 2'd0;
  logic [35:0] cwd = '0, dwd = '0;
  logic        drr = 1'b0, dwr = 1'b0;
  logic [2:0]  dport = 3'd0, dcnt = 3'd0;
  logic [2:0]  idle_port = 3'd0;
  logic [35:0] cpu_rdata, dev_rdata;
  logic        irq_req, dev_ack, dev_link_ok;
  logic [2:0]  irq_pri;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbl_buf_dctl i_dbl_buf_dctl (
    .clk(clk), .rst(rst), .cpu_valid(cv), .cpu_op(cop), .cpu_wdata(cwd),
    .cpu_rdata(cpu_rdata), .irq_req(irq_req), .irq_pri(irq_pri),
    .dev_rd_req(drr), .dev_wr_req(dwr), .dev_port(dport), .dev_cnt(dcnt),
    .dev_wdata(dwd), .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_link_ok(dev_link_ok));

  // Behavioural reference model
  logic [15:0] m_st;
  logic [35:0] m_buf, m_acc, m_rd, m_drd;
  bit          m_ack, m_link;
  int          m_tmr;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_buf = 0; m_acc = 0; m_rd = 0; m_drd = 0;
      m_ack = 0; m_link = 0; m_tmr = 0;
    end else begin : mdl
      bit busy, fire, rq, ac, mv, dir, hit, nack;
      int nt;
      busy = cv && cop != 2'd1;
      fire = (m_tmr == 1);
      rq = m_st[9]; ac = m_st[10]; mv = m_st[11]; dir = m_st[8];
      hit = (dport == m_st[5:3]);
      nack = 0;
      nt = (m_tmr > 0) ? m_tmr - 1 : 0;
      m_link = hit && !(dir && ac);
      if (cv && cop == 2'd1) m_rd = {20'd0, m_st};
      if (busy) begin
        if (cop == 2'd0) m_st = {3'd0, cwd[12:0]};
        else if (rq) begin
          if (cop == 2'd2) m_rd = m_buf; else m_buf = cwd;
          m_st = (m_st & 16'h1DFF) | 16'h0800;
          nt = 10;
        end else if (cop == 2'd2) m_rd = 0;
      end else if (drr && hit && dir && !ac) begin
        nack = 1; m_drd = m_acc;
        m_st = (m_st & 16'h1FFF) | 16'h0C00 | {dcnt, 13'd0};
        nt = 20;
      end else if (dwr && hit && !dir && !ac) begin
        nack = 1; m_acc = dwd;
        m_st = (m_st & 16'h1FFF) | 16'h0C00 | {dcnt, 13'd0};
        nt = 20;
      end else if (fire && mv && ac && !rq) begin
        if (dir) m_acc = m_buf; else m_buf = m_acc;
        m_st = (m_st & 16'hF3FF) | 16'h0200;
      end
      m_ack = nack;
      m_tmr = nt;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      cycles++;
      chk(cpu_rdata == m_rd, "R2 cpu_rdata", cpu_rdata, m_rd);
      chk(irq_req == m_st[9], "R11 irq_req", 36'(irq_req), 36'(m_st[9]));
      chk(irq_pri == m_st[2:0], "R11 irq_pri", 36'(irq_pri), 36'(m_st[2:0]));
      chk(dev_ack == m_ack, "R7 dev_ack", 36'(dev_ack), 36'(m_ack));
      chk(dev_rdata == m_drd, "R7 dev_rdata", dev_rdata, m_drd);
      chk(dev_link_ok == m_link, "R10 dev_link_ok", 36'(dev_link_ok), 36'(m_link));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      miscompares++;
      $display("FAIL watchdog R1: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic cyc(input bit v, input logic [1:0] o, input logic [35:0] w,
                     input bit rr, input bit wr, input logic [2:0] p,
                     input logic [2:0] c, input logic [35:0] dw);
    cv = v; cop = o; cwd = w; drr = rr; dwr = wr; dport = p; dcnt = c; dwd = dw;
    @(posedge clk); #1;
    cv = 0; cop = 0; cwd = 0; drr = 0; dwr = 0; dport = idle_port; dcnt = 0; dwd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic stat_is(input logic [15:0] exp, input string tag);
    cyc(1, 2'd1, 0, 0, 0, idle_port, 0, 0);
    chk(cpu_rdata == {20'd0, exp}, tag, cpu_rdata, {20'd0, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk(cpu_rdata == 0 && irq_req == 0 && dev_ack == 0 && dev_link_ok == 0,
        "R1 outputs after reset", cpu_rdata, 0);
    stat_is(16'h0000, "R1 status after reset");
    // R2 control write, junk upper bits ignored
    cyc(1, 2'd0, 36'hFFFFFE355, 0, 0, 0, 0, 0);
    stat_is(16'h0355, "R2 status load");
    chk(irq_req == 1 && irq_pri == 3'd5, "R11 irq after load", 36'({irq_req, irq_pri}), 36'h0D);
    // R9 wrong port denied
    cyc(0, 0, 0, 1, 0, 3'd3, 3'd6, 0);
    chk(dev_ack == 0, "R9 wrong port ack", 36'(dev_ack), 0);
    chk(dev_link_ok == 0, "R10 wrong port link", 36'(dev_link_ok), 0);
    stat_is(16'h0355, "R9 status untouched");
    // R3 data write with request
    cyc(1, 2'd3, 36'h123456789, 0, 0, 0, 0, 0);
    chk(irq_req == 0, "R3 irq cleared", 36'(irq_req), 0);
    stat_is(16'h0955, "R3 status after data write");
    idle(12);
    stat_is(16'h0955, "R6 no move without accumulator-full");
    // R7 device read grant and R5 delay
    idle_port = 3'd2;
    cyc(0, 0, 0, 1, 0, 3'd2, 3'd6, 0);
    chk(dev_ack == 1 && dev_rdata == 0, "R7 first grant", dev_rdata, 0);
    idle(19);
    chk(irq_req == 0, "R5 move not yet due", 36'(irq_req), 0);
    chk(dev_link_ok == 0, "R10 out dir with full accumulator", 36'(dev_link_ok), 0);
    idle(1);
    chk(irq_req == 1, "R5 move at delay", 36'(irq_req), 1);
    stat_is(16'hC355, "R6 status after move");
    cyc(0, 0, 0, 1, 0, 3'd2, 3'd1, 0);
    chk(dev_ack == 1 && dev_rdata == 36'h123456789, "R7 word delivered", dev_rdata, 36'h123456789);
    idle(25);
    stat_is(16'h2F55, "R6 request set blocks move");
    // R8 device write in direction 0
    cyc(1, 2'd0, 36'h23, 0, 0, 0, 0, 0);
    idle_port = 3'd4;
    cyc(0, 0, 0, 1, 0, 3'd4, 3'd2, 0);
    chk(dev_ack == 0, "R9 wrong direction ack", 36'(dev_ack), 0);
    cyc(0, 0, 0, 0, 1, 3'd4, 3'd2, 36'hABCDE0123);
    chk(dev_ack == 1, "R8 write grant", 36'(dev_ack), 1);
    idle(20);
    stat_is(16'h4223, "R8 status after inbound move");
    cyc(1, 2'd2, 0, 0, 0, 3'd4, 0, 0);
    chk(cpu_rdata == 36'hABCDE0123, "R3 data read", cpu_rdata, 36'hABCDE0123);
    stat_is(16'h0823, "R3 status after data read");
    cyc(1, 2'd2, 0, 0, 0, 3'd4, 0, 0);
    chk(cpu_rdata == 0, "R4 data read without request", cpu_rdata, 0);
    stat_is(16'h0823, "R4 status unchanged");
    // R12 processor op beats device request
    cyc(1, 2'd0, 36'h23, 0, 1, 3'd4, 3'd2, 36'h5);
    chk(dev_ack == 0, "R12 device blocked", 36'(dev_ack), 0);
    stat_is(16'h0023, "R12 control write won");
    cyc(0, 0, 0, 0, 1, 3'd4, 3'd2, 36'h777);
    idle(19);
    cyc(1, 2'd3, 36'h999, 0, 0, 3'd4, 0, 0);
    stat_is(16'h4C23, "R12 due move dropped");
    idle(30);
    stat_is(16'h4C23, "R12 move stays dropped");
    // Random phase against the model
    idle_port = 3'd0;
    for (int i = 0; i < 4000; i++) begin
      bit v;
      logic [35:0] w;
      v = ($urandom_range(0, 5) == 0);
      w = {$urandom, $urandom};
      w[5:3] = 3'($urandom_range(0, 1));
      cyc(v, 2'($urandom_range(0, 3)), w, $urandom_range(0, 2) == 0,
          $urandom_range(0, 2) == 0, 3'($urandom_range(0, 1)),
          3'($urandom_range(0, 7)), {$urandom, $urandom});
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 12));
    end
    finish_run();
  end
endmodule